// File: doc/BRIEF.md
# Flag-setting integer ALU

This block is the integer datapath slice of a small processor core. It takes two 32-bit operands and a 4-bit operation code and combinationally produces a result, a destination write-enable and the next value of a four-bit condition flag set: negative (N), zero (Z), carry (C) and overflow (V). The flag set is held in a register inside the block. That register loads the next flags when a flag-enable strobe is high. The registered carry feeds back into add-with-carry and subtract-with-carry.

Operations fall into three classes. Arithmetic operations compute all four flags. Logical, move and multiply operations compute only N and Z and keep C and V. One reserved code does nothing. Compare-type operations produce flags but request no destination write. Shifts, register storage, memory access and instruction decode belong to neighbouring blocks.

Top module: `flag_alu`

## Requirements
- R1: For every code except 15, the next-flag output flags_nxt_o (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V) carries bit 31 of result_o as N, and Z is 1 exactly when result_o is zero.
- R2: Add-type codes are 0 (a+b), 1 (a+b+C) and 6 (compare-negative, a+b). For these, C is the unsigned carry out of a_i+b_i and V is 1 when a_i and b_i share a sign that differs from the result's sign. For code 1, the incoming carry enters the result but not the evaluation of C.
- R3: Subtract-type codes are 2 (a−b) and 5 (compare, a−b). For these, C is 1 when a_i ≥ b_i as unsigned values, and V is 1 when a_i and b_i differ in sign and the result's sign differs from a_i's sign.
- R4: Code 3 (subtract-with-carry) forms b' = b_i + (NOT C) modulo 2^32 and returns a_i − b'. Its C and V follow the R3 rules, applied to a_i and b'.
- R5: Code 4 (negate) returns 0 − b_i with the R3 flag rules applied to 0 and b_i, so C is 1 only for b_i = 0 and V is 1 only for b_i = 0x80000000.
- R6: Codes 5, 6 and 7 (compare, compare-negative, bit test) and 15 drive wr_en_o low. All other codes drive it high.
- R7: Codes 7 (a AND b), 8 (AND), 9 (XOR), 10 (OR), 11 (a AND NOT b), 12 (NOT b), 13 (move) and 14 (multiply) pass the registered C and V through to flags_nxt_o unchanged.
- R8: Code 13 returns the low 8 bits of b_i zero-extended. Code 14 returns the low 32 bits of a_i × b_i.
- R9: flags_o is 0 while rst_ni is low. flags_o takes flags_nxt_o at a rising clock edge where flag_en_i is high, and holds its value otherwise.
- R10: Code 15 is reserved. It drives result_o to zero, drives wr_en_o low, and makes flags_nxt_o equal flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (immediate source for move) |
| flag_en_i | input | 1 | Load flags_nxt_o into the flag register |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write request |
| flags_nxt_o | output | 4 | Next flags {N,Z,C,V} |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The properties assume that op_i, a_i, b_i and flag_en_i are settled and known at each rising edge once reset is released. The bench guarantees this by changing these inputs only on falling edges. Every code is legal, so the stimulus mixes directed corner vectors with uniformly random codes, operands and enable values. The carry-dependent operations are reached with both carry values, because earlier vectors set or clear C through the flag register.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_NEG = 4'd4,
    OP_CMP = 4'd5,
    OP_CMN = 4'd6,
    OP_TST = 4'd7,
    OP_AND = 4'd8,
    OP_EOR = 4'd9,
    OP_ORR = 4'd10,
    OP_BIC = 4'd11,
    OP_MVN = 4'd12,
    OP_MOV = 4'd13,
    OP_MUL = 4'd14,
    OP_NOP = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_NONE  = 2'd2
  } alu_cls_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic alu_cls_e op_class(alu_op_e op);
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_NEG, OP_CMP, OP_CMN:          return CLS_ARITH;
      OP_NOP:                          return CLS_NONE;
      default:                         return CLS_LOGIC;
    endcase
  endfunction

  function automatic logic op_writes(alu_op_e op);
    return !(op inside {OP_CMP, OP_CMN, OP_TST, OP_NOP});
  endfunction

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_i,
  output logic [W-1:0]   res_o,
  output logic           c_o,
  output logic           v_o
);

  localparam int MSB = W - 1;

  logic         sub_mode;
  logic         cin_add;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W:0]   base_sum;

  always_comb begin
    sub_mode = op_i inside {OP_SUB, OP_SBC, OP_NEG, OP_CMP};
    lhs      = (op_i == OP_NEG) ? '0 : a_i;
    // inverted carry folds into the subtrahend before flags are formed
    rhs      = (op_i == OP_SBC) ? b_i + {{(W-1){1'b0}}, ~c_i} : b_i;
    cin_add  = (op_i == OP_ADC) & c_i;
    base_sum = {1'b0, lhs} + {1'b0, rhs};
    if (sub_mode) begin
      res_o = lhs - rhs;
      c_o   = (lhs >= rhs);
      v_o   = (lhs[MSB] != rhs[MSB]) && (res_o[MSB] != lhs[MSB]);
    end else begin
      res_o = base_sum[W-1:0] + {{(W-1){1'b0}}, cin_add};
      // carry taken from operands only, carry-in excluded
      c_o   = base_sum[W];
      v_o   = (lhs[MSB] == rhs[MSB]) && (res_o[MSB] != lhs[MSB]);
    end
  end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  localparam logic [W-1:0] IMM_MASK = {{(W-IMM_W){1'b0}}, {IMM_W{1'b1}}};

  logic [W-1:0] prod;

  assign prod = a_i * b_i;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR:         res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      OP_MOV:         res_o = b_i & IMM_MASK;
      OP_MUL:         res_o = prod;
      default:        res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_en_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_nxt_o,
  output logic [3:0]   flags_o
);

  alu_op_e      op;
  alu_cls_e     cls;
  flags_t       flags_q;
  flags_t       flags_d;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;
  logic         arith_c;
  logic         arith_v;

  assign op  = alu_op_e'(op_i);
  assign cls = op_class(op);

  alu_arith #(.W(W)) u_arith (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .c_i   (flags_q.c),
    .res_o (arith_res),
    .c_o   (arith_c),
    .v_o   (arith_v)
  );

  alu_logic #(.W(W), .IMM_W(IMM_W)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (logic_res)
  );

  always_comb begin
    flags_d  = flags_q;
    result_o = '0;
    unique case (cls)
      CLS_ARITH: begin
        result_o  = arith_res;
        flags_d.n = arith_res[W-1];
        flags_d.z = (arith_res == '0);
        flags_d.c = arith_c;
        flags_d.v = arith_v;
      end
      CLS_LOGIC: begin
        result_o  = logic_res;
        flags_d.n = logic_res[W-1];
        flags_d.z = (logic_res == '0);
      end
      default: ;
    endcase
  end

  assign wr_en_o     = op_writes(op);
  assign flags_nxt_o = flags_d;
  assign flags_o     = flags_q;

  alu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (flag_en_i),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

endmodule

// File: rtl/flag_alu_chk.sv
`timescale 1ns/1ps
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         flag_en_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_nxt_o,
  input logic [3:0]   flags_o
);

  // R1
  nz_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 4'd15) |-> (flags_nxt_o[3] == result_o[W-1]) && (flags_nxt_o[2] == (result_o == '0)));

  // R3
  sub_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2 || op_i == 4'd5) |-> (flags_nxt_o[1] == (a_i >= b_i)));

  // R5
  neg_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |-> (flags_nxt_o[1] == (b_i == '0)));

  // R6
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd5, 4'd6, 4'd7}) |-> !wr_en_o);

  // R7
  keep_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd7 && op_i <= 4'd14) |-> (flags_nxt_o[1:0] == flags_o[1:0]));

  // R9
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i |=> (flags_o == $past(flags_nxt_o)));

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(flags_o));

  // R10
  reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd15) |-> !wr_en_o && (result_o == '0) && (flags_nxt_o == flags_o));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .flag_en_i   (flag_en_i),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flags_nxt_o (flags_nxt_o),
  .flags_o     (flags_o)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        flag_en_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_nxt_o;
  logic [3:0]  flags_o;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  logic [3:0] m_flags = 4'h0;

  always #2.5 clk_i = ~clk_i;

  flag_alu u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .flag_en_i   (flag_en_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .flags_nxt_o (flags_nxt_o),
    .flags_o     (flags_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: result, write request, next flags {N,Z,C,V}
  function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] fl, output logic [31:0] r,
                                output logic w, output logic [3:0] nf);
    longint unsigned x, y, t;
    logic c, v;
    c = fl[1];
    v = fl[0];
    x = 64'(a);
    y = 64'(b);
    r = '0;
    case (op)
      0, 1, 6: begin
        t = x + y;
        r = t[31:0] + ((op == 1 && fl[1]) ? 32'd1 : 32'd0);
        c = t[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      2, 3, 4, 5: begin
        if (op == 4) x = 0;
        if (op == 3) y = (y + (fl[1] ? 64'd0 : 64'd1)) & 64'hFFFF_FFFF;
        r = 32'(x - y);
        c = (x >= y);
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
      7, 8:    r = a & b;
      9:       r = a ^ b;
      10:      r = a | b;
      11:      r = a & ~b;
      12:      r = ~b;
      13:      r = {24'd0, b[7:0]};
      14:      begin t = x * y; r = t[31:0]; end
      default: r = '0;
    endcase
    w  = !(op == 5 || op == 6 || op == 7 || op == 15);
    nf = (op == 15) ? fl : {r[31], (r == 32'd0), c, v};
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic en, input string req);
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
    @(negedge clk_i);
    op_i = 4'(op); a_i = a; b_i = b; flag_en_i = en;
    #1;
    model(op, a, b, m_flags, er, ew, ef);
    check(result_o === er, req, "result", result_o, er);
    check(wr_en_o === ew, (op inside {5, 6, 7}) ? "R6" : req, "wr_en", 32'(wr_en_o), 32'(ew));
    check(flags_nxt_o === ef, req, "flags_nxt", 32'(flags_nxt_o), 32'(ef));
    check(flags_o === m_flags, "R9", "flags_reg", 32'(flags_o), 32'(m_flags));
    @(posedge clk_i);
    if (en) m_flags = ef;
  endtask

  function automatic string req_of(int op);
    case (op)
      0, 1, 6: return "R2";
      2, 5:    return "R3";
      3:       return "R4";
      4:       return "R5";
      13, 14:  return "R8";
      15:      return "R10";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check(flags_o === 4'h0, "R9", "reset flags", 32'(flags_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 sign and zero
    apply(0, 32'h8000_0000, 32'h0, 1'b1, "R1");
    apply(12, 32'h0, 32'hFFFF_FFFF, 1'b0, "R1");
    // R2 unsigned carry and signed overflow on add
    apply(0, 32'hFFFF_FFFF, 32'h1, 1'b1, "R2");
    apply(1, 32'hFFFF_FFFF, 32'h0, 1'b1, "R2");
    apply(0, 32'h7FFF_FFFF, 32'h1, 1'b0, "R2");
    apply(6, 32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    // R4 with carry clear (b wraps to zero) then carry set
    apply(3, 32'h7, 32'hFFFF_FFFF, 1'b1, "R4");
    apply(3, 32'h7, 32'h2, 1'b1, "R4");
    apply(3, 32'h0, 32'h0, 1'b0, "R4");
    // R3 borrow and overflow
    apply(2, 32'h5, 32'h5, 1'b0, "R3");
    apply(2, 32'h3, 32'h5, 1'b0, "R3");
    apply(5, 32'h8000_0000, 32'h1, 1'b1, "R3");
    // R5 negate corners
    apply(4, 32'h0, 32'h0, 1'b0, "R5");
    apply(4, 32'h0, 32'h8000_0000, 1'b0, "R5");
    apply(4, 32'h0, 32'h1, 1'b0, "R5");
    // R6 flag-only codes
    apply(5, 32'h10, 32'h20, 1'b0, "R6");
    apply(6, 32'h10, 32'h20, 1'b0, "R6");
    apply(7, 32'hF0F0, 32'h0F0F, 1'b0, "R6");
    // R7 C and V are 1 here from the compare above
    for (int k = 7; k <= 14; k++) apply(k, 32'hA5A5_0F0F, 32'h0FF0_1234, 1'b0, "R7");
    // R8 move immediate and multiply
    apply(13, 32'hDEAD_BEEF, 32'h1234_ABCD, 1'b0, "R8");
    apply(14, 32'h0001_0001, 32'h0001_0001, 1'b0, "R8");
    apply(14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8");
    // R9 hold with enable low
    apply(0, 32'hFFFF_FFFF, 32'h1, 1'b0, "R9");
    apply(2, 32'h1, 32'h2, 1'b0, "R9");
    // R10 reserved
    apply(15, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R10");

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 15));
      apply(op, $urandom, (i % 5 == 0) ? 32'($urandom_range(0, 3)) : $urandom,
            1'($urandom), req_of(op));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule